// File: doc/BRIEF.md
# Split-Fill Micro Translation Buffer

This block is a small, fully associative first-level data translation buffer. It sits in front of a larger unified second-level TLB. A lookup carries a virtual address and an access kind. A hit returns, one cycle after the lookup is accepted, the physical page number and the read, write and execute permission bits of the cached 4 KiB page. If the access kind is not allowed by those bits, the response carries a fault and no translation.

On a miss the block holds the virtual page number on a request channel to the second level. It stalls further lookups until the translation comes back. The returned translation may describe a region of 4 KiB, 64 KiB, 1 MiB or 2 MiB. In every case the block writes exactly one entry, and that entry describes only the 4 KiB slice the faulting address falls in. The slice's physical page number takes the region base for its upper bits and the virtual page number for the offset bits inside the region.

Victims are chosen in round-robin order. A cyclic sweep over one page more than the entry count therefore misses on every access. A flush input empties the whole buffer in one cycle.

Top module: `utlb_splinter`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and miss_valid are 0, and the buffer holds no valid entry.
- R2: A lookup accepted (req_valid and req_ready high at a clock edge) whose page number bits [VA_W-1:12] match a valid entry produces rsp_valid for exactly the next cycle, with that entry's page number and permissions, and raises no miss request.
- R3: A lookup that misses raises miss_valid in the next cycle, with miss_vpn equal to the address bits [VA_W-1:12]. miss_valid and miss_vpn hold until miss_ready is seen, and req_ready stays 0 from the miss until the fill has been taken.
- R4: After the miss request is taken, a fill_valid pulse writes one entry and produces rsp_valid in the following cycle, carrying the translation of the missing address.
- R5: fill_size encodes the region size as 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB, 3 = 2 MiB. The stored and returned page number keeps fill_ppn above bit n and takes bits [n-1:0] from the virtual page number, with n = 0, 4, 8, 9 for those codes.
- R6: A fill of a large region caches only the accessed 4 KiB slice. A later lookup of another 4 KiB page in the same region misses.
- R7: Permission bits are coded as bit 0 read, bit 1 write, bit 2 execute, and are returned unchanged on rsp_perm.
- R8: req_acc codes the access as 0 read, 1 write, 2 execute, 3 reserved. rsp_fault is 1 and rsp_ppn is 0 when the matching permission bit is clear, and always for code 3.
- R9: Fills replace entries in round-robin order starting at entry 0. 32 distinct pages all hit once filled, and a cyclic sweep over 33 distinct pages misses on every access.
- R10: A flush cycle invalidates every entry and resets the victim pointer to entry 0. req_ready is 0 during that cycle, and the next accepted lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries this cycle |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_vaddr | input | VA_W | Virtual address of the lookup |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_fault | output | 1 | Permission fault on the response |
| rsp_ppn | output | PPN_W | Physical page number (0 on fault) |
| rsp_perm | output | 3 | Permission bits of the translation |
| miss_valid | output | 1 | Translation request to the second level |
| miss_ready | input | 1 | Second level takes the request |
| miss_vpn | output | VA_W-12 | Virtual page number being requested |
| fill_valid | input | 1 | Translation returned from the second level |
| fill_ppn | input | PPN_W | Region base physical page number |
| fill_size | input | 2 | Region size code |
| fill_perm | input | 3 | Region permission bits |

## Verification
Several patterns drive the lookup path. Repeats and same-page offsets separate hits from misses. Fills of every size code use base numbers with nonzero low bits, so a wrong splice boundary shows up as a wrong page number. Probing a neighbouring page inside an already-filled large region separates a correct one-slice fill from one that would cover the whole region. A fill of 32 pages followed by cyclic sweeps over 33 pages tells round-robin replacement from any policy that would keep some of the pages resident, and access kinds against mixed permission sets distinguish faults from clean hits.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

   // access kinds carried on req_acc
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MISS = 2'd1,
      ST_FILL = 2'd2
   } state_e;

   localparam int PERM_W    = 3;
   localparam int SIZE_W    = 2;
   // widest region offset in 4 KiB units (2 MiB region -> 9 bits)
   localparam int SPLIT_MAX = 9;

   // number of page-number bits a region of the given size code spans
   function automatic int split_bits(input logic [SIZE_W-1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 9;
      endcase
   endfunction

   // does the permission set allow the access kind
   function automatic logic perm_ok(input logic [PERM_W-1:0] perm,
                                    input logic [1:0] acc);
      case (acc)
         ACC_READ:  return perm[0];
         ACC_WRITE: return perm[1];
         ACC_EXEC:  return perm[2];
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/utlb_splice.sv
// Builds the 4 KiB slice page number out of a region base and the
// offset bits of the virtual page number inside that region.
module utlb_splice
   import utlb_pkg::*;
#(
   parameter int PPN_W = 20
) (
   input  logic [PPN_W-1:0]     base_ppn,
   input  logic [SPLIT_MAX-1:0] vpn_lo,
   input  logic [SIZE_W-1:0]    size_code,
   output logic [PPN_W-1:0]     slice_ppn
);

   if (PPN_W < SPLIT_MAX) begin : g_chk_w
      $error("utlb_splice: PPN_W must cover the widest region offset");
   end

   always_comb begin
      int nb;
      nb        = split_bits(size_code);
      slice_ppn = base_ppn;
      for (int i = 0; i < SPLIT_MAX; i++) begin
         if (i < nb) slice_ppn[i] = vpn_lo[i];
      end
   end

endmodule

// File: rtl/utlb_victim.sv
// Round-robin victim pointer; binary counter or one-hot ring.
module utlb_victim #(
   parameter int ENTRIES = 32,
   parameter bit ONEHOT  = 1'b0,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] idx
);

   if (ENTRIES < 2) begin : g_chk_n
      $error("utlb_victim: ENTRIES must be at least 2");
   end

   if (ONEHOT) begin : g_ring
      logic [ENTRIES-1:0] ring_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            ring_q <= {{(ENTRIES-1){1'b0}}, 1'b1};
         end else if (advance) begin
            ring_q <= {ring_q[ENTRIES-2:0], ring_q[ENTRIES-1]};
         end
      end

      always_comb begin
         idx = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (ring_q[i]) idx = idx | IDX_W'(i);
         end
      end
   end else begin : g_count
      localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
      logic [IDX_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            cnt_q <= '0;
         end else if (advance) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end

      assign idx = cnt_q;
   end

endmodule

// File: rtl/utlb_cam.sv
// Fully associative entry store: parallel tag match, single write port,
// single-cycle invalidate of all entries.
module utlb_cam
   import utlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [VPN_W-1:0]  look_vpn,
   output logic              hit,
   output logic [PPN_W-1:0]  hit_ppn,
   output logic [PERM_W-1:0] hit_perm,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [PERM_W-1:0] wr_perm
);

   logic [ENTRIES-1:0] match;
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [PERM_W-1:0]  perm_q [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic             vld_q;
      logic [VPN_W-1:0] tag_q;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            vld_q <= 1'b0;
         end else if (sel) begin
            vld_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q     <= '0;
            ppn_q[g]  <= '0;
            perm_q[g] <= '0;
         end else if (sel) begin
            tag_q     <= wr_vpn;
            ppn_q[g]  <= wr_ppn;
            perm_q[g] <= wr_perm;
         end
      end

      assign match[g] = vld_q && (tag_q == look_vpn);
   end

   // a page is only ever filled after it missed, so at most one entry
   // matches; an AND-OR read mux is enough
   always_comb begin
      hit      = |match;
      hit_ppn  = '0;
      hit_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) begin
            hit_ppn  = hit_ppn  | ppn_q[i];
            hit_perm = hit_perm | perm_q[i];
         end
      end
   end

endmodule

// File: rtl/utlb_ctrl.sv
// Sequencer: idle lookups, miss request, fill wait.
module utlb_ctrl
   import utlb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic req_valid,
   input  logic hit,
   input  logic miss_ready,
   input  logic fill_valid,
   output logic req_ready,
   output logic miss_valid,
   output logic load_hit,
   output logic load_fill
);

   state_e state_q, state_d;
   logic   req_fire;

   assign req_ready  = (state_q == ST_IDLE) && !flush;
   assign req_fire   = req_valid && req_ready;
   assign miss_valid = (state_q == ST_MISS);
   assign load_hit   = req_fire && hit;
   assign load_fill  = (state_q == ST_FILL) && fill_valid;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (req_fire && !hit) state_d = ST_MISS;
         ST_MISS: if (miss_ready)       state_d = ST_FILL;
         ST_FILL: if (fill_valid)       state_d = ST_IDLE;
         default:                       state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/utlb_splinter.sv
module utlb_splinter
   import utlb_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PPN_W      = 20,
   parameter int ENTRIES    = 32,
   parameter int PAGE_SHIFT = 12,
   parameter bit ONEHOT_RR  = 1'b0,
   localparam int VPN_W     = VA_W - PAGE_SHIFT,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [1:0]        req_acc,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [PPN_W-1:0]  rsp_ppn,
   output logic [PERM_W-1:0] rsp_perm,
   output logic              miss_valid,
   input  logic              miss_ready,
   output logic [VPN_W-1:0]  miss_vpn,
   input  logic              fill_valid,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [SIZE_W-1:0] fill_size,
   input  logic [PERM_W-1:0] fill_perm
);

   if (PAGE_SHIFT != 12) begin : g_chk_page
      $error("utlb_splinter: the base granule is 4 KiB");
   end
   if (VPN_W < SPLIT_MAX) begin : g_chk_vpn
      $error("utlb_splinter: VA_W too small for the largest region");
   end

   logic [VPN_W-1:0]  look_vpn;
   logic              hit;
   logic [PPN_W-1:0]  hit_ppn;
   logic [PERM_W-1:0] hit_perm;
   logic              load_hit;
   logic              load_fill;
   logic [IDX_W-1:0]  victim;
   logic [PPN_W-1:0]  slice_ppn;
   logic [VPN_W-1:0]  pend_vpn_q;
   logic [1:0]        pend_acc_q;
   logic              unused_offset;

   assign look_vpn      = req_vaddr[VA_W-1:PAGE_SHIFT];
   assign unused_offset = ^req_vaddr[PAGE_SHIFT-1:0];

   utlb_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .req_valid  (req_valid),
      .hit        (hit),
      .miss_ready (miss_ready),
      .fill_valid (fill_valid),
      .req_ready  (req_ready),
      .miss_valid (miss_valid),
      .load_hit   (load_hit),
      .load_fill  (load_fill)
   );

   utlb_cam #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .look_vpn (look_vpn),
      .hit      (hit),
      .hit_ppn  (hit_ppn),
      .hit_perm (hit_perm),
      .wr_en    (load_fill),
      .wr_idx   (victim),
      .wr_vpn   (pend_vpn_q),
      .wr_ppn   (slice_ppn),
      .wr_perm  (fill_perm)
   );

   utlb_victim #(
      .ENTRIES (ENTRIES),
      .ONEHOT  (ONEHOT_RR)
   ) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (flush),
      .advance (load_fill),
      .idx     (victim)
   );

   utlb_splice #(
      .PPN_W (PPN_W)
   ) u_splice (
      .base_ppn  (fill_ppn),
      .vpn_lo    (pend_vpn_q[SPLIT_MAX-1:0]),
      .size_code (fill_size),
      .slice_ppn (slice_ppn)
   );

   // the looked-up page waits here while the second level answers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vpn_q <= '0;
         pend_acc_q <= '0;
      end else if (req_valid && req_ready) begin
         pend_vpn_q <= look_vpn;
         pend_acc_q <= req_acc;
      end
   end

   assign miss_vpn = pend_vpn_q;

   // response register, loaded by a hit or by the fill
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_ppn   <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= load_hit || load_fill;
         if (load_hit) begin
            rsp_fault <= !perm_ok(hit_perm, req_acc);
            rsp_ppn   <= perm_ok(hit_perm, req_acc) ? hit_ppn : '0;
            rsp_perm  <= hit_perm;
         end else if (load_fill) begin
            rsp_fault <= !perm_ok(fill_perm, pend_acc_q);
            rsp_ppn   <= perm_ok(fill_perm, pend_acc_q) ? slice_ppn : '0;
            rsp_perm  <= fill_perm;
         end
      end
   end

endmodule

// File: rtl/utlb_splinter_chk.sv
module utlb_splinter_chk #(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_fault,
   input logic [PPN_W-1:0] rsp_ppn,
   input logic             miss_valid,
   input logic             miss_ready,
   input logic [VPN_W-1:0] miss_vpn
);

   // R3: no new lookup while a miss is outstanding
   assert_ready_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> !req_ready);

   // R3: request stays put until taken
   assert_miss_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && !miss_ready) |=> (miss_valid && $stable(miss_vpn)));

   // R3: no response while the request is pending
   assert_no_rsp_in_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> !rsp_valid);

   // R2: an accepted lookup is followed by a response or a miss request
   assert_accept_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid || miss_valid));

   // R8: a fault never carries a translation
   assert_fault_no_ppn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_ppn == '0));

   // R10: lookups are held off during a flush
   assert_flush_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !req_ready);

   // R10: the first lookup right after a flush misses
   assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 (req_valid && req_ready) |=> miss_valid);

endmodule

bind utlb_splinter utlb_splinter_chk #(
   .VPN_W (VPN_W),
   .PPN_W (PPN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_fault  (rsp_fault),
   .rsp_ppn    (rsp_ppn),
   .miss_valid (miss_valid),
   .miss_ready (miss_ready),
   .miss_vpn   (miss_vpn)
);

// File: tb/tb_utlb_splinter.sv
module tb_utlb_splinter;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 13;

   // {req, vaddr, acc, fill_ppn, fill_size, fill_perm, exp_miss, exp_ppn, exp_perm, exp_fault}
   localparam logic [87:0] VEC [NV] = '{
      {4'd4, 32'h0000_1000, 2'd0, 20'h00ABC, 2'd0, 3'b111, 1'b1, 20'h00ABC, 3'b111, 1'b0}, // R4 first fill
      {4'd2, 32'h0000_1000, 2'd0, 20'h00000, 2'd0, 3'b000, 1'b0, 20'h00ABC, 3'b111, 1'b0}, // R2 repeat hit
      {4'd2, 32'h0000_1234, 2'd1, 20'h00000, 2'd0, 3'b000, 1'b0, 20'h00ABC, 3'b111, 1'b0}, // R2 same page
      {4'd5, 32'h0043_5000, 2'd0, 20'h12340, 2'd1, 3'b001, 1'b1, 20'h12345, 3'b001, 1'b0}, // R5 64K
      {4'd6, 32'h0043_6000, 2'd0, 20'h12340, 2'd1, 3'b001, 1'b1, 20'h12346, 3'b001, 1'b0}, // R6 neighbour
      {4'd8, 32'h0043_5000, 2'd1, 20'h00000, 2'd0, 3'b000, 1'b0, 20'h00000, 3'b001, 1'b1}, // R8 write denied
      {4'd8, 32'h0043_5000, 2'd2, 20'h00000, 2'd0, 3'b000, 1'b0, 20'h00000, 3'b001, 1'b1}, // R8 exec denied
      {4'd5, 32'h0789_A000, 2'd0, 20'h555FF, 2'd2, 3'b101, 1'b1, 20'h5559A, 3'b101, 1'b0}, // R5 1M
      {4'd7, 32'h0789_A000, 2'd2, 20'h00000, 2'd0, 3'b000, 1'b0, 20'h5559A, 3'b101, 1'b0}, // R7 exec ok
      {4'd5, 32'h0ABC_D000, 2'd0, 20'h77777, 2'd3, 3'b011, 1'b1, 20'h777CD, 3'b011, 1'b0}, // R5 2M
      {4'd6, 32'h0ABC_C000, 2'd0, 20'h77777, 2'd3, 3'b011, 1'b1, 20'h777CC, 3'b011, 1'b0}, // R6 neighbour
      {4'd8, 32'h0ABC_D000, 2'd3, 20'h00000, 2'd0, 3'b000, 1'b0, 20'h00000, 3'b011, 1'b1}, // R8 reserved
      {4'd7, 32'h0ABC_D000, 2'd1, 20'h00000, 2'd0, 3'b000, 1'b0, 20'h777CD, 3'b011, 1'b0}  // R7 write ok
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [19:0] rsp_ppn;
   logic [2:0]  rsp_perm;
   logic        miss_valid;
   logic        miss_ready = 1'b0;
   logic [19:0] miss_vpn;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_ppn = '0;
   logic [1:0]  fill_size = '0;
   logic [2:0]  fill_perm = '0;

   int checks = 0;
   int errors = 0;
   int sweep_miss = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   utlb_splinter dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_vaddr  (req_vaddr),
      .req_acc    (req_acc),
      .rsp_valid  (rsp_valid),
      .rsp_fault  (rsp_fault),
      .rsp_ppn    (rsp_ppn),
      .rsp_perm   (rsp_perm),
      .miss_valid (miss_valid),
      .miss_ready (miss_ready),
      .miss_vpn   (miss_vpn),
      .fill_valid (fill_valid),
      .fill_ppn   (fill_ppn),
      .fill_size  (fill_size),
      .fill_perm  (fill_perm)
   );

   task automatic check(input string tag, input logic ok,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one lookup; serves the second-level side if a miss appears
   task automatic access(input string tag, input logic [31:0] va, input logic [1:0] acc,
                         input logic [19:0] fppn, input logic [1:0] fsz, input logic [2:0] fperm,
                         input logic exp_miss, input logic [19:0] exp_ppn,
                         input logic [2:0] exp_perm, input logic exp_flt);
      logic got_miss;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      req_acc   = acc;
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b0;
      got_miss = miss_valid;
      if (got_miss) begin
         check({tag, " R3 miss_vpn/ready"}, miss_vpn == va[31:12] && !req_ready,
               {43'd0, req_ready, miss_vpn}, {44'd0, va[31:12]});
         @(negedge clk);
         @(posedge clk); #1;
         check({tag, " R3 hold"}, miss_valid && miss_vpn == va[31:12] && !req_ready,
               {43'd0, miss_valid, miss_vpn}, {43'd1, va[31:12]});
         @(negedge clk);
         miss_ready = 1'b1;
         @(posedge clk); #1;
         miss_ready = 1'b0;
         @(negedge clk);
         fill_valid = 1'b1;
         fill_ppn   = fppn;
         fill_size  = fsz;
         fill_perm  = fperm;
         @(posedge clk); #1;
         fill_valid = 1'b0;
      end
      check(tag, rsp_valid && got_miss == exp_miss && rsp_ppn == exp_ppn &&
                 rsp_perm == exp_perm && rsp_fault == exp_flt,
            {38'd0, rsp_valid, got_miss, rsp_ppn, rsp_perm, rsp_fault},
            {38'd0, 1'b1, exp_miss, exp_ppn, exp_perm, exp_flt});
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      #1;
      check("R10 ready low in flush", !req_ready, {63'd0, req_ready}, 64'd0);
      @(posedge clk); #1;
      flush = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset outputs", req_ready && !rsp_valid && !miss_valid,
            {61'd0, req_ready, rsp_valid, miss_valid}, 64'd4);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 after release", req_ready && !rsp_valid && !miss_valid,
            {61'd0, req_ready, rsp_valid, miss_valid}, 64'd4);

      // table walk (R1: the very first lookup must miss)
      for (int k = 0; k < NV; k++) begin
         automatic logic [87:0] v = VEC[k];
         access($sformatf("vec%0d R%0d", k, v[87:84]), v[83:52], v[51:50], v[49:30],
                v[29:28], v[27:25], v[24], v[23:4], v[3:1], v[0]);
      end

      // R10: flush empties everything
      do_flush();
      access("R10 miss after flush", 32'h0000_1000, 2'd0, 20'h00DEF, 2'd0, 3'b001,
             1'b1, 20'h00DEF, 3'b001, 1'b0);
      access("R10 refilled hit", 32'h0000_1000, 2'd0, 20'h0, 2'd0, 3'b000,
             1'b0, 20'h00DEF, 3'b001, 1'b0);

      // R9: fill 32 pages, all resident, then thrash with 33
      do_flush();
      for (int i = 0; i < 32; i++)
         access("R9 fill", {12'd0, 8'(8'h00 + i) + 20'h100, 12'h000}, 2'd0,
                20'h300 + 20'(i), 2'd0, 3'b001, 1'b1, 20'h300 + 20'(i), 3'b001, 1'b0);
      for (int i = 0; i < 32; i++)
         access("R9 resident hit", {12'd0, 20'h100 + 20'(i), 12'h000}, 2'd0,
                20'h0, 2'd0, 3'b000, 1'b0, 20'h300 + 20'(i), 3'b001, 1'b0);
      access("R9 33rd page", {12'd0, 20'h120, 12'h000}, 2'd0, 20'h320, 2'd0, 3'b001,
             1'b1, 20'h320, 3'b001, 1'b0);
      for (int p = 0; p < 2; p++)
         for (int i = 0; i < 33; i++) begin
            access("R9 sweep", {12'd0, 20'h100 + 20'(i), 12'h000}, 2'd0,
                   20'h300 + 20'(i), 2'd0, 3'b001, 1'b1, 20'h300 + 20'(i), 3'b001, 1'b0);
            sweep_miss++;
         end
      check("R9 sweep length", sweep_miss == 66, 64'(sweep_miss), 64'd66);

      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule